// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one decoded operand specifier into an effective address and an operand value. A request carries a 4-bit addressing-mode code, a base and an index register number, a 16-bit constant field and a 2-bit access-size code. The block reads two register-file ports, forms the address, performs the one or two memory reads the mode needs, and returns the operand, the address and a one-cycle done strobe. For post-increment and pre-decrement modes it also returns the updated base-register value on a write-back port in the same cycle as done.

The memory side is a request/valid read port. The block holds the request and its address until the memory answers, so any latency is tolerated. Requests are taken only while the block is idle. The asynchronous active-low reset is released to the logic through a short synchronizer.

Top module: `opnd_ea_gen`

## Requirements
- R1: Mode 0 (register) returns the base register value as the operand, makes no memory read, reports address 0, and asserts done in the second cycle after the accepting clock edge.
- R2: Mode 1 (immediate) returns the 16-bit field sign-extended to 32 bits as the operand, reports address 0 and makes no memory read.
- R3: Mode 2 uses address = sign-extended field + base register; mode 3 uses the base register alone; mode 5 uses the sign-extended field alone. Each makes one read, and the operand is the data read at that address.
- R4: Mode 4 (indexed) uses address = base register + index register and makes one read.
- R5: Mode 9 (scaled) uses address = sign-extended field + base + (index shifted left by k), where size code 0, 1, 2 gives k = 0, 1, 2 (d = 1, 2, 4 bytes) and size code 3 acts as code 2.
- R6: Mode 6 (memory-indirect) makes two reads: the first at the base register value returns a pointer, the second at that pointer returns the operand; the reported address is the pointer.
- R7: Mode 7 (post-increment) reads at the base register value and writes back base + d to the base register.
- R8: Mode 8 (pre-decrement) reads at base − d and writes back base − d to the base register.
- R9: Codes 10 to 15 raise the illegal flag together with done, make no memory read, and report operand 0 and address 0.
- R10: While a memory read is outstanding the request stays high and its address stays constant until valid is seen.
- R11: Done is high for exactly one cycle per accepted request; ready is high only while idle, and a request presented while busy is ignored and produces no further done.
- R12: The write-back enable is high only in modes 7 and 8, and only in the done cycle; in every other mode no write-back occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New operand request |
| req_ready | output | 1 | Block idle, request will be taken |
| req_mode | input | 4 | Addressing-mode code |
| req_base | input | 4 | Base register number |
| req_index | input | 4 | Index register number |
| req_field | input | 16 | Displacement, immediate or absolute constant |
| req_size | input | 2 | Access size code (1, 2, 4 bytes) |
| rf_a_idx | output | 4 | Register-file port A read index (base) |
| rf_a_data | input | 32 | Register-file port A read data |
| rf_b_idx | output | 4 | Register-file port B read index (index) |
| rf_b_data | input | 32 | Register-file port B read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| done | output | 1 | One-cycle result strobe |
| opnd | output | 32 | Operand value, valid with done |
| ea | output | 32 | Effective address, valid with done |
| illegal | output | 1 | Illegal mode code, valid with done |
| wb_en | output | 1 | Base register write-back enable |
| wb_idx | output | 4 | Write-back register number |
| wb_data | output | 32 | Write-back value |

## Verification
On every cycle the assertions check the memory handshake (request and address held until valid), the single-cycle done pulse, that ready excludes any read or result, that the illegal flag and write-back only appear with done, that an illegal result carries zero values, and that a write-back value differs from the address by 0 or by a legal step. Only the bench scenarios can show the arithmetic of each mode, the two-read order of the indirect mode, the register-mode latency, the per-size scaling including size code 3, and that a request raised while busy leaves no trace, since these need a reference model of the register file and memory.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;

  localparam logic [3:0] MD_REG  = 4'd0;
  localparam logic [3:0] MD_IMM  = 4'd1;
  localparam logic [3:0] MD_DISP = 4'd2;
  localparam logic [3:0] MD_RIND = 4'd3;
  localparam logic [3:0] MD_IDX  = 4'd4;
  localparam logic [3:0] MD_ABS  = 4'd5;
  localparam logic [3:0] MD_MIND = 4'd6;
  localparam logic [3:0] MD_AINC = 4'd7;
  localparam logic [3:0] MD_ADEC = 4'd8;
  localparam logic [3:0] MD_SCL  = 4'd9;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CALC = 3'd1,
    ST_RD1  = 3'd2,
    ST_RD2  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic illegal;
    logic uses_mem;
    logic two_level;
    logic writes_base;
    logic opnd_reg;
    logic opnd_imm;
    logic add_field;
    logic add_base;
    logic add_index;
    logic scale_index;
    logic pre_dec;
  } mode_ctl_t;

endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import opnd_ea_pkg::*;
(
  input  logic [3:0] mode,
  output mode_ctl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (mode)
      MD_REG:  ctl.opnd_reg = 1'b1;
      MD_IMM:  ctl.opnd_imm = 1'b1;
      MD_DISP: begin ctl.uses_mem = 1'b1; ctl.add_field = 1'b1; ctl.add_base = 1'b1; end
      MD_RIND: begin ctl.uses_mem = 1'b1; ctl.add_base = 1'b1; end
      MD_IDX:  begin ctl.uses_mem = 1'b1; ctl.add_base = 1'b1; ctl.add_index = 1'b1; end
      MD_ABS:  begin ctl.uses_mem = 1'b1; ctl.add_field = 1'b1; end
      MD_MIND: begin ctl.uses_mem = 1'b1; ctl.two_level = 1'b1; ctl.add_base = 1'b1; end
      MD_AINC: begin ctl.uses_mem = 1'b1; ctl.add_base = 1'b1; ctl.writes_base = 1'b1; end
      MD_ADEC: begin
        ctl.uses_mem = 1'b1; ctl.add_base = 1'b1; ctl.writes_base = 1'b1; ctl.pre_dec = 1'b1;
      end
      MD_SCL:  begin
        ctl.uses_mem = 1'b1; ctl.add_field = 1'b1; ctl.add_base = 1'b1;
        ctl.add_index = 1'b1; ctl.scale_index = 1'b1;
      end
      default: ctl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import opnd_ea_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 16
) (
  input  mode_ctl_t           ctl,
  input  logic [DATA_W-1:0]   base_val,
  input  logic [DATA_W-1:0]   index_val,
  input  logic [FIELD_W-1:0]  field,
  input  logic [1:0]          size,
  output logic [DATA_W-1:0]   field_ext,
  output logic [DATA_W-1:0]   ea_val,
  output logic [DATA_W-1:0]   wb_val
);
  localparam int EXT_W = DATA_W - FIELD_W;

  logic [1:0]        shamt;
  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] base_dec;
  logic [DATA_W-1:0] base_term;
  logic [DATA_W-1:0] idx_term;
  logic [DATA_W-1:0] fld_term;

  assign field_ext = {{EXT_W{field[FIELD_W-1]}}, field};

  always_comb begin
    case (size)
      2'd0:    shamt = 2'd0;
      2'd1:    shamt = 2'd1;
      default: shamt = 2'd2;
    endcase
  end

  assign step      = {{(DATA_W-1){1'b0}}, 1'b1} << shamt;
  assign base_dec  = base_val - step;
  assign base_term = ctl.add_base  ? (ctl.pre_dec ? base_dec : base_val) : '0;
  assign idx_term  = ctl.add_index ? (ctl.scale_index ? (index_val << shamt) : index_val) : '0;
  assign fld_term  = ctl.add_field ? field_ext : '0;
  assign ea_val    = fld_term + base_term + idx_term;
  assign wb_val    = ctl.pre_dec ? base_dec : (base_val + step);
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import opnd_ea_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FIELD_W   = 16,
  parameter int REG_IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [3:0]            req_mode,
  input  logic [REG_IDX_W-1:0]  req_base,
  input  logic [REG_IDX_W-1:0]  req_index,
  input  logic [FIELD_W-1:0]    req_field,
  input  logic [1:0]            req_size,
  output logic [3:0]            mode_q,
  output logic [REG_IDX_W-1:0]  base_q,
  output logic [REG_IDX_W-1:0]  index_q,
  output logic [FIELD_W-1:0]    field_q,
  output logic [1:0]            size_q,
  input  mode_ctl_t             ctl,
  input  logic [DATA_W-1:0]     rf_base_val,
  input  logic [DATA_W-1:0]     field_ext,
  input  logic [DATA_W-1:0]     ea_calc,
  input  logic [DATA_W-1:0]     wb_calc,
  output logic                  mem_req,
  output logic [DATA_W-1:0]     mem_addr,
  input  logic                  mem_valid,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  done,
  output logic [DATA_W-1:0]     opnd,
  output logic [DATA_W-1:0]     ea,
  output logic                  illegal,
  output logic                  wb_en,
  output logic [DATA_W-1:0]     wb_data
);
  seq_state_e        state_q, state_d;
  logic              ld_en;
  logic              res_en;
  logic [DATA_W-1:0] ea_q, ea_d;
  logic [DATA_W-1:0] opnd_q, opnd_d;
  logic [DATA_W-1:0] wb_q, wb_d;

  assign ld_en = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    res_en  = 1'b0;
    ea_d    = ea_q;
    opnd_d  = opnd_q;
    wb_d    = wb_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_CALC;
      ST_CALC: begin
        res_en = 1'b1;
        ea_d   = ea_calc;
        wb_d   = wb_calc;
        opnd_d = ctl.opnd_reg ? rf_base_val : (ctl.opnd_imm ? field_ext : '0);
        state_d = ctl.uses_mem ? ST_RD1 : ST_DONE;
      end
      ST_RD1: if (mem_valid) begin
        res_en = 1'b1;
        if (ctl.two_level) begin
          ea_d    = mem_rdata;
          state_d = ST_RD2;
        end else begin
          opnd_d  = mem_rdata;
          state_d = ST_DONE;
        end
      end
      ST_RD2: if (mem_valid) begin
        res_en  = 1'b1;
        opnd_d  = mem_rdata;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      base_q  <= '0;
      index_q <= '0;
      field_q <= '0;
      size_q  <= '0;
    end else if (ld_en) begin
      mode_q  <= req_mode;
      base_q  <= req_base;
      index_q <= req_index;
      field_q <= req_field;
      size_q  <= req_size;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q   <= '0;
      opnd_q <= '0;
      wb_q   <= '0;
    end else if (res_en) begin
      ea_q   <= ea_d;
      opnd_q <= opnd_d;
      wb_q   <= wb_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_addr  = ea_q;
  assign done      = (state_q == ST_DONE);
  assign opnd      = opnd_q;
  assign ea        = ea_q;
  assign illegal   = done && ctl.illegal;
  assign wb_en     = done && ctl.writes_base;
  assign wb_data   = wb_q;
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import opnd_ea_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FIELD_W     = 16,
  parameter int REG_IDX_W   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [3:0]            req_mode,
  input  logic [REG_IDX_W-1:0]  req_base,
  input  logic [REG_IDX_W-1:0]  req_index,
  input  logic [FIELD_W-1:0]    req_field,
  input  logic [1:0]            req_size,
  output logic [REG_IDX_W-1:0]  rf_a_idx,
  input  logic [DATA_W-1:0]     rf_a_data,
  output logic [REG_IDX_W-1:0]  rf_b_idx,
  input  logic [DATA_W-1:0]     rf_b_data,
  output logic                  mem_req,
  output logic [DATA_W-1:0]     mem_addr,
  input  logic                  mem_valid,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  done,
  output logic [DATA_W-1:0]     opnd,
  output logic [DATA_W-1:0]     ea,
  output logic                  illegal,
  output logic                  wb_en,
  output logic [REG_IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0]     wb_data
);
  logic                 rst_n_sync;
  logic [3:0]           mode_q;
  logic [REG_IDX_W-1:0] base_q;
  logic [REG_IDX_W-1:0] index_q;
  logic [FIELD_W-1:0]   field_q;
  logic [1:0]           size_q;
  mode_ctl_t            ctl;
  logic [DATA_W-1:0]    field_ext;
  logic [DATA_W-1:0]    ea_calc;
  logic [DATA_W-1:0]    wb_calc;

  ea_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  ea_mode_dec u_dec (
    .mode (mode_q),
    .ctl  (ctl)
  );

  ea_addr_calc #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_calc (
    .ctl       (ctl),
    .base_val  (rf_a_data),
    .index_val (rf_b_data),
    .field     (field_q),
    .size      (size_q),
    .field_ext (field_ext),
    .ea_val    (ea_calc),
    .wb_val    (wb_calc)
  );

  ea_seq #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .REG_IDX_W(REG_IDX_W)) u_seq (
    .clk         (clk),
    .rst_ni      (rst_n_sync),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mode    (req_mode),
    .req_base    (req_base),
    .req_index   (req_index),
    .req_field   (req_field),
    .req_size    (req_size),
    .mode_q      (mode_q),
    .base_q      (base_q),
    .index_q     (index_q),
    .field_q     (field_q),
    .size_q      (size_q),
    .ctl         (ctl),
    .rf_base_val (rf_a_data),
    .field_ext   (field_ext),
    .ea_calc     (ea_calc),
    .wb_calc     (wb_calc),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .mem_rdata   (mem_rdata),
    .done        (done),
    .opnd        (opnd),
    .ea          (ea),
    .illegal     (illegal),
    .wb_en       (wb_en),
    .wb_data     (wb_data)
  );

  assign rf_a_idx = base_q;
  assign rf_b_idx = index_q;
  assign wb_idx   = base_q;
endmodule

// File: rtl/ea_chk.sv
module ea_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              done,
  input logic [DATA_W-1:0] opnd,
  input logic [DATA_W-1:0] ea,
  input logic              illegal,
  input logic              wb_en,
  input logic [DATA_W-1:0] wb_data
);
  logic [DATA_W-1:0] wb_diff;
  assign wb_diff = wb_data - ea;

  // R10: outstanding read keeps request and address
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: idle excludes reads and results
  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !done));

  // R9: illegal only with done, zero results
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && opnd == '0 && ea == '0 && !wb_en));

  // R12: write-back only in the done cycle
  a_r12_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R7 R8: write-back equals address (pre-decrement) or address plus a step
  a_r7_r8_wb_step: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_diff == 0 || wb_diff == 1 || wb_diff == 2 || wb_diff == 4));
endmodule

bind opnd_ea_gen ea_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_valid (mem_valid),
  .done      (done),
  .opnd      (opnd),
  .ea        (ea),
  .illegal   (illegal),
  .wb_en     (wb_en),
  .wb_data   (wb_data)
);

// File: tb/sim_opnd_ea_gen.sv
module sim_opnd_ea_gen;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_mode;
  logic [3:0]  req_base;
  logic [3:0]  req_index;
  logic [15:0] req_field;
  logic [1:0]  req_size;
  logic [3:0]  rf_a_idx;
  logic [31:0] rf_a_data;
  logic [3:0]  rf_b_idx;
  logic [31:0] rf_b_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;
  logic        done;
  logic [31:0] opnd;
  logic [31:0] ea;
  logic        illegal;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;

  logic [31:0] regs [16];
  int          checks = 0;
  int          errors = 0;
  int          lat = 0;
  int          wait_cnt = 0;
  int          rd_cnt = 0;
  int          cyc = 0;

  opnd_ea_gen u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign rf_a_data = regs[rf_a_idx];
  assign rf_b_data = regs[rf_b_idx];

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // memory stub: answers after lat cycles, one-cycle valid
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_valid = 1'b1;
        mem_rdata = mem_fn(mem_addr);
        rd_cnt++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic model(input logic [3:0] m, input logic [3:0] b, input logic [3:0] x,
                       input logic [15:0] f, input logic [1:0] s,
                       output logic [31:0] e_op, output logic [31:0] e_ea,
                       output logic e_ill, output logic e_wb, output logic [31:0] e_wbd,
                       output int e_rd);
    logic [31:0] sx, av, bv, d, p;
    int k;
    sx = {{16{f[15]}}, f};
    av = regs[b];
    bv = regs[x];
    k  = (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
    d  = 32'd1 << k;
    e_op = 0; e_ea = 0; e_ill = 0; e_wb = 0; e_wbd = 0; e_rd = 1;
    case (m)
      4'd0: begin e_op = av; e_rd = 0; end
      4'd1: begin e_op = sx; e_rd = 0; end
      4'd2: e_ea = sx + av;
      4'd3: e_ea = av;
      4'd4: e_ea = av + bv;
      4'd5: e_ea = sx;
      4'd6: begin p = mem_fn(av); e_ea = p; e_rd = 2; end
      4'd7: begin e_ea = av; e_wb = 1; e_wbd = av + d; end
      4'd8: begin e_ea = av - d; e_wb = 1; e_wbd = av - d; end
      4'd9: e_ea = sx + av + (bv << k);
      default: begin e_ill = 1; e_rd = 0; end
    endcase
    if (m >= 4'd2 && m <= 4'd9) e_op = mem_fn(e_ea);
  endtask

  task automatic run_op(input string tag, input logic [3:0] m, input logic [3:0] b,
                        input logic [3:0] x, input logic [15:0] f, input logic [1:0] s,
                        input int exp_lat);
    logic [31:0] e_op, e_ea, e_wbd;
    logic e_ill, e_wb;
    int e_rd, n, rd0;
    model(m, b, x, f, s, e_op, e_ea, e_ill, e_wb, e_wbd, e_rd);
    @(negedge clk);
    req_mode = m; req_base = b; req_index = x; req_field = f; req_size = s;
    req_valid = 1'b1;
    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!done && n < 80) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s R11: actual no done expected done", tag);
      return;
    end
    if (exp_lat > 0) chk({tag, " R1 latency"}, n, exp_lat);
    chk({tag, " opnd"}, opnd, e_op);
    chk({tag, " ea"}, ea, e_ea);
    chk({tag, " R9 illegal"}, {31'd0, illegal}, {31'd0, e_ill});
    chk({tag, " R12 wb_en"}, {31'd0, wb_en}, {31'd0, e_wb});
    if (e_wb) begin
      chk({tag, " wb_data"}, wb_data, e_wbd);
      chk({tag, " wb_idx"}, {28'd0, wb_idx}, {28'd0, b});
    end
    chk({tag, " reads"}, rd_cnt - rd0, e_rd);
    if (wb_en) regs[wb_idx] = wb_data;
    @(negedge clk);
    chk({tag, " R11 single done"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    req_valid = 1'b0; req_mode = 0; req_base = 0; req_index = 0; req_field = 0; req_size = 0;
    mem_valid = 1'b0; mem_rdata = 0;
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
    repeat (3) @(negedge clk);
    chk("reset R11 ready", {31'd0, req_ready}, 32'd1);
    chk("reset R11 done", {31'd0, done}, 32'd0);
    chk("reset R10 mem_req", {31'd0, mem_req}, 32'd0);
    chk("reset R12 wb_en", {31'd0, wb_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corner cases
    regs[1] = 32'h0000_1000; regs[2] = 32'h0000_0010; regs[3] = 32'hFFFF_FFFF;
    run_op("R1 register",       4'd0, 4'd1, 4'd0, 16'h0000, 2'd0, 2);
    run_op("R2 imm negative",   4'd1, 4'd0, 4'd0, 16'h8000, 2'd0, 2);
    run_op("R2 imm positive",   4'd1, 4'd0, 4'd0, 16'h7FFF, 2'd0, 2);
    run_op("R3 disp negative",  4'd2, 4'd1, 4'd0, 16'hFFF0, 2'd0, 0);
    run_op("R3 reg indirect",   4'd3, 4'd2, 4'd0, 16'h0000, 2'd0, 0);
    run_op("R3 absolute",       4'd5, 4'd0, 4'd0, 16'h9234, 2'd0, 0);
    run_op("R4 indexed",        4'd4, 4'd1, 4'd3, 16'h0000, 2'd0, 0);
    run_op("R5 scaled size0",   4'd9, 4'd1, 4'd2, 16'h0004, 2'd0, 0);
    run_op("R5 scaled size1",   4'd9, 4'd1, 4'd2, 16'h0004, 2'd1, 0);
    run_op("R5 scaled size2",   4'd9, 4'd1, 4'd2, 16'hFFFC, 2'd2, 0);
    run_op("R5 scaled size3",   4'd9, 4'd1, 4'd2, 16'h0004, 2'd3, 0);
    run_op("R6 mem indirect",   4'd6, 4'd2, 4'd0, 16'h0000, 2'd0, 0);
    run_op("R7 autoinc size1",  4'd7, 4'd1, 4'd0, 16'h0000, 2'd1, 0);
    run_op("R7 autoinc again",  4'd7, 4'd1, 4'd0, 16'h0000, 2'd2, 0);
    run_op("R8 autodec size0",  4'd8, 4'd2, 4'd0, 16'h0000, 2'd0, 0);
    run_op("R8 autodec wrap",   4'd8, 4'd5, 4'd0, 16'h0000, 2'd2, 0);
    run_op("R9 illegal 10",     4'd10, 4'd1, 4'd2, 16'h1234, 2'd2, 2);
    run_op("R9 illegal 15",     4'd15, 4'd1, 4'd2, 16'h1234, 2'd2, 2);
    lat = 7;
    run_op("R10 slow memory",   4'd6, 4'd1, 4'd0, 16'h0000, 2'd0, 0);

    // R11: a request raised while busy is ignored
    begin
      logic [31:0] e_op, e_ea, e_wbd;
      logic e_ill, e_wb;
      int e_rd, n, extra;
      model(4'd5, 4'd0, 4'd0, 16'h0040, 2'd0, e_op, e_ea, e_ill, e_wb, e_wbd, e_rd);
      @(negedge clk);
      req_mode = 4'd5; req_base = 0; req_index = 0; req_field = 16'h0040; req_size = 0;
      req_valid = 1'b1;
      @(negedge clk);
      req_mode = 4'd1; req_field = 16'h0BAD;
      n = 1;
      while (!done && n < 80) begin
        @(negedge clk);
        n++;
      end
      req_valid = 1'b0;
      chk("R11 busy ignored opnd", opnd, e_op);
      chk("R11 busy ignored ea", ea, e_ea);
      extra = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R11 no extra done", extra, 0);
    end

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [3:0] m;
      lat = $urandom % 4;
      if (($urandom % 8) == 0) regs[$urandom % 16] = $urandom;
      m = (($urandom % 10) == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
      run_op($sformatf("rand%0d R%0d", i, (m < 4'd10) ? 3 : 9), m, 4'($urandom),
             4'($urandom), 16'($urandom), 2'($urandom), (m < 4'd2 || m > 4'd9) ? 2 : 0);
    end

    summary();
    $finish;
  end
endmodule